// File: doc/BRIEF.md
# Capability Load/Store Permission Checker

This block sits in the load/store path of a core that uses hardware capabilities as memory pointers. Each request presents the authorizing capability, the kind of access, the access address and size, and the capability word being moved. The authorizing capability is described by its tag, sealed flag, permission vector and decoded bounds. For a load the moved word is the one read from memory. For a store it is the one being written. One cycle later the block reports whether the access is allowed and, if it is not, a 3-bit cause.

For capability loads the block also returns the tag and permissions to write back to the register file. These are weakened when the authorizing capability does not confer the right to load global or mutable capabilities. Derived permissions count only when their base permission is present, so a malformed permission vector cannot grant more than its primary bits allow. Bounds decoding, memory and trap handling are done elsewhere.

Top module: `memAccessGuard`

## Requirements
- R1: A data or capability load with no read permission faults with cause 3. A data or capability store with no write permission faults with cause 4. Access kind codes: 0 data load, 1 data store, 2 capability load, 3 capability store.
- R2: A capability store with no effective load/store-capability permission faults with cause 5. A capability load with no such permission does not fault and returns the tag cleared.
- R3: On a capability load that returns a tag, if the authorizing capability has no effective load-global permission, the returned perms have the global bit (0) and the load-global bit (8) cleared.
- R4: On a capability load that returns a tag, if the authorizing capability has no effective load-mutable permission, the returned perms have the write bit (2) and the load-mutable bit (9) cleared.
- R5: Storing a tagged capability whose global bit is clear faults with cause 6 unless the authorizing capability has effective store-local permission.
- R6: Derived bits count only with their base permission. Load/store-capability (bit 7) needs read (1) or write (2). Load-global (8) and load-mutable (9) need read. Store-local (10) needs write. System-register access (11) needs execute (3).
- R7: An access faults with cause 7 unless address >= base and address + size <= top. The sum is taken without wraparound, and top is one bit wider than an address.
- R8: An untagged authorizing capability faults with cause 1. A sealed one faults with cause 2. Causes rank untagged, sealed, read/write, capability permission, store-local, bounds, with the first match reported. Cause 0 means no fault.
- R9: The permission vector is 12 bits: G0 R1 W2 X3 S4 U5 U0-6 c7 g8 m9 l10 a11. The returned tag is 1 only for a non-faulting capability load of a tagged word with effective load/store-capability permission. In every other case the returned tag is 0 and the returned perms equal the moved word's perms unchanged.
- R10: The response registers update on the clock edge after a valid request, with rspValid set for that one cycle. Reset clears all response outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Access kind code |
| reqAddr | input | ADDR_W | Access address |
| reqSize | input | SIZE_W | Access size in bytes |
| authTag | input | 1 | Authorizing capability tag |
| authSealed | input | 1 | Authorizing capability is sealed |
| authPerms | input | 12 | Authorizing capability permissions |
| authBase | input | ADDR_W | Lower bound, inclusive |
| authTop | input | ADDR_W+1 | Upper bound, exclusive |
| srcTag | input | 1 | Tag of the moved capability word |
| srcPerms | input | 12 | Permissions of the moved capability word |
| rspValid | output | 1 | Response present |
| rspFault | output | 1 | Access denied |
| rspCause | output | 3 | Fault cause code |
| rspTag | output | 1 | Tag to write back |
| rspPerms | output | 12 | Permissions to write back |

## Verification
A wrong decode, priority or mask in this block shows up in the response registers on the very next edge after the request. It appears as a wrong cause code, a missing fault, a tag that survives when it should be dropped, or a global or write bit left set on a loaded capability. No state carries over between requests, so each error is confined to the cycle of the request that caused it. The sweep of every permission vector under every access kind covers each dependency and attenuation path, including derived bits that are set without their base permission. The bounds edges are probed on both sides, including a top bound that lies beyond the address range.

// File: rtl/accessGuardPkg.sv
package accessGuardPkg;
  localparam int PERM_W = 12;
  // permission bit positions
  localparam int P_GL  = 0;
  localparam int P_RD  = 1;
  localparam int P_WR  = 2;
  localparam int P_EX  = 3;
  localparam int P_SE  = 4;
  localparam int P_US  = 5;
  localparam int P_SW0 = 6;
  localparam int P_CAP = 7;
  localparam int P_LGL = 8;
  localparam int P_LMU = 9;
  localparam int P_SLO = 10;
  localparam int P_SYS = 11;

  typedef enum logic [1:0] {
    K_DLOAD  = 2'd0,
    K_DSTORE = 2'd1,
    K_CLOAD  = 2'd2,
    K_CSTORE = 2'd3
  } accessKindE;

  typedef enum logic [2:0] {
    C_NONE     = 3'd0,
    C_UNTAGGED = 3'd1,
    C_SEALED   = 3'd2,
    C_NO_READ  = 3'd3,
    C_NO_WRITE = 3'd4,
    C_NO_CAP   = 3'd5,
    C_NO_LOCAL = 3'd6,
    C_BOUNDS   = 3'd7
  } faultCauseE;

  typedef struct packed {
    logic capture;
    logic keepTag;
    logic stripGlobal;
    logic stripMutable;
  } dpStrobeT;

  typedef struct packed {
    logic [PERM_W-1:0] effPerms;
    logic              inBounds;
  } dpStatusT;
endpackage

// File: rtl/guardDatapath.sv
module guardDatapath
  import accessGuardPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PERM_W-1:0] authPerms,
  input  logic [ADDR_W-1:0] authBase,
  input  logic [ADDR_W:0]   authTop,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [PERM_W-1:0] srcPerms,
  input  dpStrobeT          strobe,
  output dpStatusT          status,
  output logic              outTag,
  output logic [PERM_W-1:0] outPerms
);
  localparam int EXT_W = ADDR_W + 1;

  logic [PERM_W-1:0] effPerms;
  logic [EXT_W-1:0]  accLo;
  logic [EXT_W-1:0]  accHi;
  logic              inBounds;
  logic [PERM_W-1:0] nextPerms;

  // derived permissions masked by their base permission
  always_comb begin
    effPerms         = authPerms;
    effPerms[P_CAP]  = authPerms[P_CAP] & (authPerms[P_RD] | authPerms[P_WR]);
    effPerms[P_LGL]  = authPerms[P_LGL] & authPerms[P_RD];
    effPerms[P_LMU]  = authPerms[P_LMU] & authPerms[P_RD];
    effPerms[P_SLO]  = authPerms[P_SLO] & authPerms[P_WR];
    effPerms[P_SYS]  = authPerms[P_SYS] & authPerms[P_EX];
  end

  // bounds compare in one extra bit so the end address cannot wrap
  always_comb begin
    accLo    = {1'b0, reqAddr};
    accHi    = accLo + {{(EXT_W-SIZE_W){1'b0}}, reqSize};
    inBounds = (accLo >= {1'b0, authBase}) && (accHi <= authTop);
  end

  assign status.effPerms = effPerms;
  assign status.inBounds = inBounds;

  // attenuation of the loaded word
  always_comb begin
    nextPerms = srcPerms;
    if (strobe.stripGlobal) begin
      nextPerms[P_GL]  = 1'b0;
      nextPerms[P_LGL] = 1'b0;
    end
    if (strobe.stripMutable) begin
      nextPerms[P_WR]  = 1'b0;
      nextPerms[P_LMU] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outTag   <= 1'b0;
      outPerms <= '0;
    end else if (strobe.capture) begin
      outTag   <= strobe.keepTag;
      outPerms <= nextPerms;
    end
  end

  AST_STRIP_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.keepTag && !authPerms[P_LGL]
      |=> !outPerms[P_GL] && !outPerms[P_LGL]); // R3
  AST_STRIP_MUTABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.keepTag && !authPerms[P_LMU]
      |=> !outPerms[P_WR] && !outPerms[P_LMU]); // R4
  AST_UNTAGGED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !strobe.keepTag |=> !outTag && outPerms == $past(srcPerms)); // R9
endmodule

// File: rtl/guardControl.sv
module guardControl
  import accessGuardPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  accessKindE reqKind,
  input  logic       authTag,
  input  logic       authSealed,
  input  logic       authRead,
  input  logic       authWrite,
  input  logic       authStoreLocal,
  input  logic       srcTag,
  input  logic       srcGlobal,
  input  dpStatusT   status,
  output dpStrobeT   strobe,
  output logic       rspValid,
  output logic       rspFault,
  output logic [2:0] rspCause
);
  logic       isCap;
  logic       isStore;
  faultCauseE cause;
  logic [PERM_W-1:0] eff;

  assign isCap   = reqKind[1];
  assign isStore = reqKind[0];
  assign eff     = status.effPerms;

  // first matching cause wins
  always_comb begin
    cause = C_NONE;
    if (!authTag)                                  cause = C_UNTAGGED;
    else if (authSealed)                           cause = C_SEALED;
    else if (!isStore && !eff[P_RD])               cause = C_NO_READ;
    else if (isStore && !eff[P_WR])                cause = C_NO_WRITE;
    else if (isCap && isStore && !eff[P_CAP])      cause = C_NO_CAP;
    else if (isCap && isStore && srcTag && !srcGlobal && !eff[P_SLO])
                                                   cause = C_NO_LOCAL;
    else if (!status.inBounds)                     cause = C_BOUNDS;
  end

  always_comb begin
    strobe.capture      = reqValid;
    strobe.keepTag      = isCap && !isStore && (cause == C_NONE) && srcTag && eff[P_CAP];
    strobe.stripGlobal  = strobe.keepTag && !eff[P_LGL];
    strobe.stripMutable = strobe.keepTag && !eff[P_LMU];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCause <= 3'd0;
    end else begin
      rspValid <= reqValid;
      rspFault <= reqValid && (cause != C_NONE);
      rspCause <= reqValid ? cause : C_NONE;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10
  AST_UNTAGGED_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !authTag |=> rspFault && rspCause == 3'd1); // R8
  AST_NEED_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !isStore && !authRead |=> rspFault); // R1
  AST_NEED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isStore && !authWrite |=> rspFault); // R1
  AST_LOCAL_STORE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == K_CSTORE && srcTag && !srcGlobal && !authStoreLocal
      |=> rspFault); // R5
  AST_OUT_OF_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !status.inBounds |=> rspFault); // R7
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspCause != 3'd0 && rspValid); // R8
endmodule

// File: rtl/memAccessGuard.sv
module memAccessGuard
  import accessGuardPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              authTag,
  input  logic              authSealed,
  input  logic [11:0]       authPerms,
  input  logic [ADDR_W-1:0] authBase,
  input  logic [ADDR_W:0]   authTop,
  input  logic              srcTag,
  input  logic [11:0]       srcPerms,
  output logic              rspValid,
  output logic              rspFault,
  output logic [2:0]        rspCause,
  output logic              rspTag,
  output logic [11:0]       rspPerms
);
  dpStrobeT strobe;
  dpStatusT status;

  guardControl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqKind       (accessKindE'(reqKind)),
    .authTag       (authTag),
    .authSealed    (authSealed),
    .authRead      (authPerms[P_RD]),
    .authWrite     (authPerms[P_WR]),
    .authStoreLocal(authPerms[P_SLO] & authPerms[P_WR]),
    .srcTag        (srcTag),
    .srcGlobal     (srcPerms[P_GL]),
    .status        (status),
    .strobe        (strobe),
    .rspValid      (rspValid),
    .rspFault      (rspFault),
    .rspCause      (rspCause)
  );

  guardDatapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .authPerms(authPerms),
    .authBase (authBase),
    .authTop  (authTop),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .srcPerms (srcPerms),
    .strobe   (strobe),
    .status   (status),
    .outTag   (rspTag),
    .outPerms (rspPerms)
  );
endmodule

// File: tb/memAccessGuard_bench.sv
module memAccessGuard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqSize = '0;
  logic        authTag = 1'b0;
  logic        authSealed = 1'b0;
  logic [11:0] authPerms = '0;
  logic [31:0] authBase = '0;
  logic [32:0] authTop = '0;
  logic        srcTag = 1'b0;
  logic [11:0] srcPerms = '0;
  logic        rspValid, rspFault, rspTag;
  logic [2:0]  rspCause;
  logic [11:0] rspPerms;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  memAccessGuard u_memAccessGuard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqSize(reqSize), .authTag(authTag),
    .authSealed(authSealed), .authPerms(authPerms), .authBase(authBase),
    .authTop(authTop), .srcTag(srcTag), .srcPerms(srcPerms),
    .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
    .rspTag(rspTag), .rspPerms(rspPerms)
  );

  // Reference computed from the requirement text.
  task automatic predict(output bit eFault, output int eCause,
                         output bit eTag, output logic [11:0] ePerms);
    bit r, w, x, capOk, lgOk, lmOk, slOk, load, cap, inB;
    longint lo, hi;
    r = authPerms[1]; w = authPerms[2]; x = authPerms[3];
    capOk = authPerms[7] && (r || w);      // R6
    lgOk  = authPerms[8] && r;             // R6
    lmOk  = authPerms[9] && r;             // R6
    slOk  = authPerms[10] && w;            // R6
    load  = (reqKind == 2'd0) || (reqKind == 2'd2);
    cap   = reqKind >= 2'd2;
    lo = longint'(reqAddr);
    hi = lo + longint'(reqSize);
    inB = (lo >= longint'(authBase)) && (hi <= longint'(authTop));
    eCause = 0;
    if (!authTag) eCause = 1;
    else if (authSealed) eCause = 2;
    else if (load && !r) eCause = 3;
    else if (!load && !w) eCause = 4;
    else if (cap && !load && !capOk) eCause = 5;
    else if (cap && !load && srcTag && !srcPerms[0] && !slOk) eCause = 6;
    else if (!inB) eCause = 7;
    eFault = eCause != 0;
    ePerms = srcPerms;
    eTag = 1'b0;
    if (!eFault && cap && load && srcTag && capOk) begin
      eTag = 1'b1;
      if (!lgOk) begin ePerms[0] = 1'b0; ePerms[8] = 1'b0; end
      if (!lmOk) begin ePerms[2] = 1'b0; ePerms[9] = 1'b0; end
    end
    if (x == 1'b0 && authPerms[11]) ePerms = ePerms; // a without X grants nothing here
  endtask

  function automatic string reqOf(int c, logic [1:0] k);
    case (c)
      1, 2: return "R8";
      3, 4: return "R1";
      5: return "R2";
      6: return "R5";
      7: return "R7";
      default: return (k == 2'd2) ? "R3 R4 R9" : "R9";
    endcase
  endfunction

  task automatic runOne();
    bit eFault, eTag;
    int eCause;
    logic [11:0] ePerms;
    @(negedge clk);
    reqValid = 1'b1;
    predict(eFault, eCause, eTag, ePerms);
    @(negedge clk);
    reqValid = 1'b0;
    testsRun++;
    if (rspValid !== 1'b1 || rspFault !== eFault || rspCause !== 3'(eCause) ||
        rspTag !== eTag || rspPerms !== ePerms) begin
      testsFailed++;
      $display("FAIL %s kind=%0d auth=%h src=%h: got v=%b f=%b c=%0d t=%b p=%h exp v=1 f=%b c=%0d t=%b p=%h",
               reqOf(eCause, reqKind), reqKind, authPerms, srcPerms,
               rspValid, rspFault, rspCause, rspTag, rspPerms,
               eFault, eCause, eTag, ePerms);
    end
  endtask

  task automatic setAuth(bit t, bit s, logic [11:0] p, logic [31:0] b, logic [32:0] tp);
    authTag = t; authSealed = s; authPerms = p; authBase = b; authTop = tp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    testsRun++;
    if (rspValid !== 1'b0 || rspFault !== 1'b0 || rspCause !== 3'd0 ||
        rspTag !== 1'b0 || rspPerms !== 12'h000) begin
      testsFailed++;
      $display("FAIL R10 reset: got v=%b f=%b c=%0d t=%b p=%h exp all zero",
               rspValid, rspFault, rspCause, rspTag, rspPerms);
    end
    rstN = 1'b1;

    // R1 R2 R3 R4 R5 R6 R9: every permission vector under every kind
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4096; p++) begin
        setAuth(1'b1, 1'b0, 12'(p), 32'h0000_1000, 33'h0_0000_2000);
        reqKind  = 2'(k);
        reqAddr  = 32'h0000_1800;
        reqSize  = 4'd8;
        srcPerms = 12'({p[5:0], p[11:6]}) ^ 12'hA5C;
        srcTag   = (p % 3) != 0;
        runOne();
      end
    end

    // R7: edges around base and top
    for (int k = 0; k < 4; k++) begin
      for (int off = -4; off <= 4; off++) begin
        for (int sz = 1; sz <= 8; sz++) begin
          setAuth(1'b1, 1'b0, 12'hFFF, 32'h0000_1000, 33'h0_0000_1040);
          reqKind = 2'(k); reqSize = 4'(sz);
          srcTag = 1'b1; srcPerms = 12'hFFF;
          reqAddr = 32'(32'h1000 + off);
          runOne();
          reqAddr = 32'(32'h1040 - sz + off);
          runOne();
        end
      end
    end
    // R7: top beyond the address range, no wrap of the end address
    setAuth(1'b1, 1'b0, 12'hFFF, 32'hFFFF_FF00, 33'h1_0000_0000);
    reqKind = 2'd0; reqAddr = 32'hFFFF_FFF8; reqSize = 4'd8; runOne();
    reqSize = 4'd9; runOne();
    setAuth(1'b1, 1'b0, 12'hFFF, 32'hFFFF_FF00, 33'h0_FFFF_FFF0);
    reqSize = 4'd15; reqAddr = 32'hFFFF_FFF8; runOne();

    // R8: untagged and sealed, priority over permission and bounds causes
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int pv = 0; pv < 2; pv++) begin
          setAuth(m[0], m[1], pv != 0 ? 12'hFFF : 12'h000, 32'h0000_1000, 33'h0_0000_1010);
          reqKind = 2'(k); srcTag = 1'b1; srcPerms = 12'h3C6;
          reqAddr = 32'h0000_2000; reqSize = 4'd4;
          runOne();
        end
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule